// File: doc/BRIEF.md
# Fault Supervisor with Auto-Recovery

This block gathers six protection detectors of a peak-current-mode switching controller and decides when the controller sits in fault mode. The detectors are thermal shutdown, pin over-temperature, pin over-voltage, overload-timer expiry, short-circuit-counter expiry and supply over-voltage. It deglitches the level detectors and gates the over-temperature detector until the first soft-start has finished. On the first qualified detection it enters fault mode and records the cause. It then releases each cause by that cause's own rule.

The analog comparators sit outside the block and arrive as synchronous digital flags. The overload and short-circuit counters also sit outside and each delivers a one-cycle expiry pulse. While fault mode is active, the gate driver logic stops switching and the bias logic drops to low consumption. A synchronous controller reset returns the block to its idle state. So does the asynchronous reset.

Top module: `fault_supervisor`

## Requirements
- R1: After either reset, `fault_o`, `lowpwr_o` and `cause_o` are all zero.
- R2: A level detector qualifies only after its flag has been sampled high on `*_FILT_CYC` consecutive clock edges. Fault mode then rises on the following edge. A single low sample restarts the count.
- R3: `otp_low_i` is ignored until `ss_done_i` has been seen high since the last reset or fault exit.
- R4: An over-temperature fault clears only when two conditions hold together: `AR_CYC` cycles have passed since entry, and `otp_rec_i` is high.
- R5: A pin over-voltage fault clears only after `AR_CYC` cycles. Fault mode is held for as long as `pin_ovp_i` stays high.
- R6: An `ovld_exp_i` or `scp_exp_i` pulse enters fault mode on the edge that samples it. Fault mode ends exactly `AR_CYC`+1 edges after entry.
- R7: Thermal shutdown enters fault mode with no filter. It clears on the first edge that samples `tsd_i` low, without waiting for the timer.
- R8: A supply over-voltage fault is never released by the timer. Only a reset clears it.
- R9: `ctrl_rst_i` sampled high clears fault mode, the cause, the filters and the soft-start memory on that edge.
- R10: When `PIN_LATCH`=1, pin over-temperature and pin over-voltage faults stay latched until a reset, whatever the timer and the pin flags do.
- R11: `cause_o` records every detector that qualified on the entry edge and holds while fault mode lasts. The bit positions are: 0 thermal, 1 pin over-temperature, 2 pin over-voltage, 3 overload, 4 short circuit, 5 supply over-voltage. `cause_o` returns to zero on exit. `lowpwr_o` equals `fault_o` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctrl_rst_i | input | 1 | Synchronous controller reset |
| tsd_i | input | 1 | Die over-temperature flag (hysteresis external) |
| otp_low_i | input | 1 | Fault pin below over-temperature threshold |
| otp_rec_i | input | 1 | Fault pin above over-temperature recovery threshold |
| pin_ovp_i | input | 1 | Fault pin above over-voltage threshold |
| vcc_ovp_i | input | 1 | Supply above over-voltage threshold |
| ss_done_i | input | 1 | Soft-start finished flag |
| ovld_exp_i | input | 1 | Overload timer expiry pulse |
| scp_exp_i | input | 1 | Short-circuit counter expiry pulse |
| fault_o | output | 1 | Fault mode, switching inhibited |
| lowpwr_o | output | 1 | Low-consumption request |
| cause_o | output | 6 | Sticky record of the detectors that caused entry |

## Verification
The bench drives each filter one sample short of its count and then to its full count. A design that does not restart its count on a low sample, or that counts off by one, enters fault mode when it should not, or one edge early or late. The over-temperature flag is held high before soft-start ends: a design without the gate faults at once.

The bench holds the recovery flag low, and later the over-voltage flag high, past timer expiry. A design that releases on the timer alone restarts too early. A supply over-voltage is left for many recovery periods: a design that applies the timer to every cause lets it go. A second instance built with the latch option shows whether pin faults survive the recovery condition.

// File: rtl/fs_pkg.sv
package fs_pkg;
  localparam int unsigned NCAUSE  = 6;
  localparam int unsigned C_TSD   = 0;
  localparam int unsigned C_OTP   = 1;
  localparam int unsigned C_POVP  = 2;
  localparam int unsigned C_OVLD  = 3;
  localparam int unsigned C_SCP   = 4;
  localparam int unsigned C_VOVP  = 5;
  typedef logic [NCAUSE-1:0] cause_t;
endpackage

// File: rtl/fs_deglitch.sv
module fs_deglitch #(
  parameter int unsigned FILT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic in_i,
  output logic det_o
);
  localparam int unsigned CW = $clog2(FILT + 1) + 1;

  generate
    if (FILT == 0) begin : g_bypass
      assign det_o = in_i;
    end else begin : g_count
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                      cnt_q <= '0;
        else if (clr_i || !in_i)          cnt_q <= '0;
        else if (cnt_q != CW'(FILT))      cnt_q <= cnt_q + 1'b1;
      end
      assign det_o = (cnt_q == CW'(FILT));

      // R2: qualification only follows a high sample
      assert_det_after_high_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        det_o |-> $past(in_i));
    end
  endgenerate
endmodule

// File: rtl/fs_recovery_timer.sv
module fs_recovery_timer #(
  parameter int unsigned AR_CYC = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic run_i,
  output logic done_o
);
  localparam int unsigned TW = $clog2(AR_CYC + 1) + 1;
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                cnt_q <= '0;
    else if (start_i)                           cnt_q <= '0;
    else if (run_i && cnt_q != TW'(AR_CYC))     cnt_q <= cnt_q + 1'b1;
  end
  assign done_o = (cnt_q == TW'(AR_CYC));

  // R6: count never passes its limit
  assert_timer_bounded_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= TW'(AR_CYC));
endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor
  import fs_pkg::*;
#(
  parameter int unsigned OTP_FILT_CYC = 4000,
  parameter int unsigned OVP_FILT_CYC = 1000,
  parameter int unsigned VCC_FILT_CYC = 600,
  parameter int unsigned AR_CYC       = 200000000,
  parameter bit          PIN_LATCH    = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_rst_i,
  input  logic              tsd_i,
  input  logic              otp_low_i,
  input  logic              otp_rec_i,
  input  logic              pin_ovp_i,
  input  logic              vcc_ovp_i,
  input  logic              ss_done_i,
  input  logic              ovld_exp_i,
  input  logic              scp_exp_i,
  output logic              fault_o,
  output logic              lowpwr_o,
  output logic [NCAUSE-1:0] cause_o
);
  logic   fault_q, ss_seen_q;
  cause_t cause_q, trig, rel;
  logic   filt_clr, otp_gate, otp_det, povp_det, vovp_det;
  logic   ar_done, enter, leave;

  assign filt_clr = fault_q | ctrl_rst_i;
  assign otp_gate = ss_seen_q | ss_done_i;

  fs_deglitch #(.FILT(OTP_FILT_CYC)) u_otp (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(filt_clr),
    .in_i(otp_low_i & otp_gate), .det_o(otp_det));
  fs_deglitch #(.FILT(OVP_FILT_CYC)) u_povp (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(filt_clr),
    .in_i(pin_ovp_i), .det_o(povp_det));
  fs_deglitch #(.FILT(VCC_FILT_CYC)) u_vovp (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(filt_clr),
    .in_i(vcc_ovp_i), .det_o(vovp_det));

  always_comb begin
    trig         = '0;
    trig[C_TSD]  = tsd_i;
    trig[C_OTP]  = otp_det;
    trig[C_POVP] = povp_det;
    trig[C_OVLD] = ovld_exp_i;
    trig[C_SCP]  = scp_exp_i;
    trig[C_VOVP] = vovp_det;
  end

  assign enter = !fault_q && !ctrl_rst_i && (trig != '0);

  fs_recovery_timer #(.AR_CYC(AR_CYC)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(enter | ctrl_rst_i),
    .run_i(fault_q), .done_o(ar_done));

  // per-cause release rule
  always_comb begin
    rel         = '0;
    rel[C_TSD]  = !tsd_i;
    rel[C_OTP]  = !PIN_LATCH && ar_done && otp_rec_i;
    rel[C_POVP] = !PIN_LATCH && ar_done && !pin_ovp_i;
    rel[C_OVLD] = ar_done;
    rel[C_SCP]  = ar_done;
    rel[C_VOVP] = 1'b0;
  end

  assign leave = fault_q && ((rel | ~cause_q) == '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_q   <= 1'b0;
      cause_q   <= '0;
      ss_seen_q <= 1'b0;
    end else if (ctrl_rst_i) begin
      fault_q   <= 1'b0;
      cause_q   <= '0;
      ss_seen_q <= 1'b0;
    end else begin
      ss_seen_q <= fault_q ? 1'b0 : otp_gate;
      if (enter) begin
        fault_q <= 1'b1;
        cause_q <= trig;
      end else if (leave) begin
        fault_q <= 1'b0;
        cause_q <= '0;
      end
    end
  end

  assign fault_o  = fault_q;
  assign lowpwr_o = fault_q;
  assign cause_o  = cause_q;

  assert_cause_in_fault_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_q |-> (cause_q != '0));
  assert_cause_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_q |-> (cause_q == '0));
  assert_vcc_latched_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_q && cause_q[C_VOVP] && !ctrl_rst_i) |=> fault_q);
  assert_pin_ovp_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_q && cause_q[C_POVP] && pin_ovp_i && !ctrl_rst_i) |=> fault_q);
  assert_tsd_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_q && cause_q[C_TSD] && tsd_i && !ctrl_rst_i) |=> fault_q);
  assert_timer_exit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(fault_q) && !$past(ctrl_rst_i) && ($past(cause_q[C_OVLD]) || $past(cause_q[C_SCP])))
      |-> $past(ar_done));
  assert_otp_gated_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(fault_q) && cause_q[C_OTP]) |-> $past(ss_seen_q));
  assert_ctrl_rst_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_rst_i |=> !fault_q);
endmodule

// File: tb/sim_fault_supervisor.sv
module sim_fault_supervisor;
  localparam int OTP = 8, OVP = 5, VCC = 3, AR = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic crst = 0, tsd = 0, olow = 0, orec = 0, povp = 0, vovp = 0, ssd = 0, ovld = 0, scp = 0;
  logic f0, lp0, f1, lp1;
  logic [5:0] c0, c1;
  int checks = 0, errors = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  fault_supervisor #(.OTP_FILT_CYC(OTP), .OVP_FILT_CYC(OVP), .VCC_FILT_CYC(VCC),
    .AR_CYC(AR), .PIN_LATCH(1'b0)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_rst_i(crst), .tsd_i(tsd), .otp_low_i(olow),
    .otp_rec_i(orec), .pin_ovp_i(povp), .vcc_ovp_i(vovp), .ss_done_i(ssd),
    .ovld_exp_i(ovld), .scp_exp_i(scp), .fault_o(f0), .lowpwr_o(lp0), .cause_o(c0));

  fault_supervisor #(.OTP_FILT_CYC(OTP), .OVP_FILT_CYC(OVP), .VCC_FILT_CYC(VCC),
    .AR_CYC(AR), .PIN_LATCH(1'b1)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_rst_i(crst), .tsd_i(tsd), .otp_low_i(olow),
    .otp_rec_i(orec), .pin_ovp_i(povp), .vcc_ovp_i(vovp), .ss_done_i(ssd),
    .ovld_exp_i(ovld), .scp_exp_i(scp), .fault_o(f1), .lowpwr_o(lp1), .cause_o(c1));

  // behavioural reference for u0
  int m_otp, m_ovp, m_vcc, m_tmr;
  bit m_fault, m_ss;
  bit [5:0] m_cause;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || crst) begin
      m_otp = 0; m_ovp = 0; m_vcc = 0; m_tmr = 0;
      m_fault = 0; m_ss = 0; m_cause = 0;
    end else if (!m_fault) begin
      bit [5:0] t;
      bit gate;
      gate = m_ss || ssd;
      t = {m_vcc >= VCC, scp, ovld, m_ovp >= OVP, m_otp >= OTP, tsd};
      m_otp = (olow && gate) ? ((m_otp < OTP) ? m_otp + 1 : m_otp) : 0;
      m_ovp = povp ? ((m_ovp < OVP) ? m_ovp + 1 : m_ovp) : 0;
      m_vcc = vovp ? ((m_vcc < VCC) ? m_vcc + 1 : m_vcc) : 0;
      m_ss  = gate;
      if (t != 0) begin
        m_fault = 1; m_cause = t; m_tmr = 0;
      end
    end else begin
      bit done, ok;
      done = (m_tmr >= AR);
      ok = 1;
      if (m_cause[0] && tsd) ok = 0;
      if (m_cause[1] && !(done && orec)) ok = 0;
      if (m_cause[2] && !(done && !povp)) ok = 0;
      if ((m_cause[3] || m_cause[4]) && !done) ok = 0;
      if (m_cause[5]) ok = 0;
      m_otp = 0; m_ovp = 0; m_vcc = 0; m_ss = 0;
      if (m_tmr < AR) m_tmr++;
      if (ok) begin m_fault = 0; m_cause = 0; end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (f0 !== m_fault || c0 !== m_cause || lp0 !== f0) begin
        errors++;
        $display("FAIL %s/R11 model: fault=%b cause=%b lowpwr=%b expected fault=%b cause=%b",
                 cur_req, f0, c0, lp0, m_fault, m_cause);
      end
    end
  end

  task automatic chk(string req, logic [6:0] act, logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_crst();
    crst = 1; cyc(1); crst = 0; cyc(1);
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      errors++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(3); rst_n = 1; cyc(1);
    cur_req = "R1";
    chk("R1", {f0, c0}, 7'b0);
    chk("R1", {f1, c1}, 7'b0);

    // R3 gate: over-temperature ignored before soft-start end
    cur_req = "R3";
    olow = 1; cyc(3 * OTP);
    chk("R3", {f0, c0}, 7'b0);
    olow = 0; cyc(1);
    ssd = 1; cyc(1); ssd = 0;
    // R2 restart: one sample short, then drop
    cur_req = "R2";
    olow = 1; cyc(OTP - 1); olow = 0; cyc(1);
    chk("R2", {f0, c0}, 7'b0);
    olow = 1; cyc(OTP);
    chk("R2", {f0, c0}, 7'b0);
    cyc(1);
    chk("R2", {f0, c0}, {1'b1, 6'b000010});
    olow = 0;
    // R4: recovery threshold still low past timer
    cur_req = "R4";
    cyc(2 * AR);
    chk("R4", {f0, c0}, {1'b1, 6'b000010});
    orec = 1; cyc(1);
    chk("R4", {f0, c0}, 7'b0);
    chk("R10", {f1, c1}, {1'b1, 6'b000010});
    orec = 0;
    do_crst();
    chk("R9", {f1, c1}, 7'b0);

    // R5: pin over-voltage held high keeps fault mode
    cur_req = "R5";
    povp = 1; cyc(OVP + 1);
    chk("R5", {f0, c0}, {1'b1, 6'b000100});
    cyc(3 * AR);
    chk("R5", {f0, c0}, {1'b1, 6'b000100});
    povp = 0; cyc(1);
    chk("R5", {f0, c0}, 7'b0);
    chk("R10", {f1, c1}, {1'b1, 6'b000100});
    do_crst();

    // R6: overload and short-circuit pulses
    cur_req = "R6";
    ovld = 1; cyc(1); ovld = 0;
    chk("R6", {f0, c0}, {1'b1, 6'b001000});
    cyc(AR);
    chk("R6", {f0, c0}, {1'b1, 6'b001000});
    cyc(1);
    chk("R6", {f0, c0}, 7'b0);
    cyc(2);
    scp = 1; ovld = 1; cyc(1); scp = 0; ovld = 0;
    chk("R11", {f0, c0}, {1'b1, 6'b011000});
    cyc(AR + 1);
    chk("R6", {f0, c0}, 7'b0);

    // R7: thermal shutdown follows its flag
    cur_req = "R7";
    tsd = 1; cyc(1);
    chk("R7", {f0, c0}, {1'b1, 6'b000001});
    cyc(5);
    chk("R7", {f0, lp0}, {5'b0, 2'b11});
    tsd = 0; cyc(1);
    chk("R7", {f0, c0}, 7'b0);

    // R8: supply over-voltage latches
    cur_req = "R8";
    vovp = 1; cyc(VCC - 1); vovp = 0; cyc(2);
    chk("R2", {f0, c0}, 7'b0);
    vovp = 1; cyc(VCC + 1); vovp = 0;
    chk("R8", {f0, c0}, {1'b1, 6'b100000});
    cyc(4 * AR);
    chk("R8", {f0, c0}, {1'b1, 6'b100000});
    cur_req = "R9";
    crst = 1; cyc(1); crst = 0;
    chk("R9", {f0, c0}, 7'b0);
    chk("R9", {f1, c1}, 7'b0);

    // R9: soft-start memory cleared by controller reset
    cur_req = "R3";
    olow = 1; cyc(2 * OTP);
    chk("R3", {f0, c0}, 7'b0);
    olow = 0; cyc(2);

    // R1: asynchronous reset mid-fault
    cur_req = "R1";
    ovld = 1; cyc(1); ovld = 0; cyc(2);
    rst_n = 0; cyc(1);
    chk("R1", {f0, c0}, 7'b0);
    rst_n = 1; cyc(2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule